// File: doc/BRIEF.md
# Addressed Byte Mailbox Slave Port

This block is the slave side of an 8-bit parallel bus. An external master drives a chip select, a read strobe, a write strobe, a 2-bit address and a data byte. Four outgoing bytes are loaded by the local processor, and four incoming bytes are filled by the master. The address picks one byte from each set. The master reads outgoing bytes and writes incoming bytes. Each transaction touches only the byte that its address names.

Every outgoing byte has an empty flag, and an aggregate flag reports when all four are empty. Every incoming byte has a full flag. Reading an outgoing byte that is already empty gives an underflow pulse. Writing an incoming byte that is already full gives an overflow pulse, and the write is dropped. Each completed bus transaction sets an interrupt request, and that request stays set until the local side clears it.

All bus inputs pass through a two-stage synchronizer. A transaction is taken once, on the rising edge of its qualified strobe. The data bus is split into an input and an output with an output enable, which a pad ring turns into a tri-state pin.

Top module: `addr_slave_port`

## Requirements
- R1: While chip select and the read strobe are both active, `ext_data_oe` is 1. `ext_data_out` then carries the outgoing byte at index `ext_addr`: 0 is buffer one low, 1 is buffer one high, 2 is buffer two low and 3 is buffer two high.
- R2: While chip select or the read strobe is inactive, `ext_data_oe` is 0.
- R3: A bus read sets the empty flag (`out_empty[index]`) of the byte it reads.
- R4: A local load (`loc_wr_en`) stores `loc_wr_data` into outgoing byte `loc_wr_sel` and clears that byte's empty flag.
- R5: `all_empty` is 1 exactly when all four bits of `out_empty` are 1.
- R6: A bus read of a byte whose empty flag is already set raises `underflow_evt` for one clock cycle.
- R7: A bus write stores `ext_data_in` into incoming byte `ext_addr`, using the same index mapping, and sets `in_full[index]`.
- R8: A bus write to a full incoming byte raises `overflow_evt` for one cycle. The stored byte keeps its old value.
- R9: `loc_rd_data` shows incoming byte `loc_rd_sel`. A `loc_rd_en` pulse clears that byte's full flag.
- R10: Each completed bus read or write sets `irq_flag`. It stays set until an `irq_clr` pulse clears it.
- R11: A strobe that is held active acts only once. It produces at most one underflow pulse and one flag update.
- R12: After reset, all outgoing bytes are empty and `all_empty` is 1. No incoming byte is full, and `irq_flag`, `ext_data_oe` and both event outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_cs | input | 1 | Bus chip select, active high |
| ext_rd | input | 1 | Bus read strobe, active high |
| ext_wr | input | 1 | Bus write strobe, active high |
| ext_addr | input | AW | Bus byte index |
| ext_data_in | input | DW | Bus data from master |
| ext_data_out | output | DW | Bus data to master |
| ext_data_oe | output | 1 | Output enable for the bus data pads |
| loc_wr_en | input | 1 | Local load strobe for an outgoing byte |
| loc_wr_sel | input | AW | Outgoing byte index for the load |
| loc_wr_data | input | DW | Byte to load |
| loc_rd_en | input | 1 | Local read acknowledge for an incoming byte |
| loc_rd_sel | input | AW | Incoming byte index to view |
| loc_rd_data | output | DW | Selected incoming byte |
| out_empty | output | 2**AW | Per-byte empty flags, outgoing side |
| all_empty | output | 1 | All outgoing bytes empty |
| in_full | output | 2**AW | Per-byte full flags, incoming side |
| irq_flag | output | 1 | Transaction interrupt request |
| irq_clr | input | 1 | Clears irq_flag |
| underflow_evt | output | 1 | One-cycle read-of-empty pulse |
| overflow_evt | output | 1 | One-cycle write-to-full pulse |

## Verification
Random sequences mix local loads, bus reads, bus writes and local reads over random indices. The scoreboard tracks each byte's data and flag, so a mismatch separates a wrong index mapping from a flag that belongs to the wrong byte. Directed cases cover the following:
- reading every byte twice, which separates setting the empty flag from raising the underflow pulse;
- writing a full byte, which shows that the overflow keeps the old data;
- holding a strobe for many cycles, which shows whether the edge detector acts once or every cycle.

// File: rtl/aps_pkg.sv
package aps_pkg;
  // Byte roles on the bus; index value is the bus address.
  typedef enum logic [1:0] {
    SLOT_B1_LO = 2'd0,
    SLOT_B1_HI = 2'd1,
    SLOT_B2_LO = 2'd2,
    SLOT_B2_HI = 2'd3
  } slot_e;

  localparam int unsigned MASK_W = 16;

  // One-hot decode of a byte index (index width up to 4 bits).
  function automatic logic [MASK_W-1:0] sel_mask(input logic [3:0] idx);
    logic [MASK_W-1:0] m;
    m = '0;
    m[idx] = 1'b1;
    return m;
  endfunction

  // Rising-edge detection of a qualified strobe.
  function automatic logic rise(input logic now_v, input logic was_v);
    return now_v & ~was_v;
  endfunction

  // Next value of a set/clear flag; set has priority.
  function automatic logic flag_next(input logic cur, input logic set_v, input logic clr_v);
    return set_v | (cur & ~clr_v);
  endfunction
endpackage

// File: rtl/aps_sync.sv
module aps_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(STAGES); i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < int'(STAGES); i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/aps_strobe_edge.sv
module aps_strobe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic rd,
  input  logic wr,
  output logic rd_act,
  output logic rd_go,
  output logic wr_go
);
  import aps_pkg::*;

  logic wr_act;
  logic rd_was, wr_was;

  assign rd_act = cs & rd;
  assign wr_act = cs & wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_was <= 1'b0;
      wr_was <= 1'b0;
    end else begin
      rd_was <= rd_act;
      wr_was <= wr_act;
    end
  end

  assign rd_go = rise(rd_act, rd_was);
  assign wr_go = rise(wr_act, wr_was);
endmodule

// File: rtl/aps_out_bank.sv
module aps_out_bank #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 2,
  localparam int unsigned NB = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [AW-1:0] load_sel,
  input  logic [DW-1:0] load_data,
  input  logic          take_en,
  input  logic [AW-1:0] take_sel,
  output logic [DW-1:0] take_data,
  output logic [NB-1:0] empty,
  output logic          underflow_evt
);
  import aps_pkg::*;

  logic [DW-1:0]     mem [NB];
  logic [MASK_W-1:0] ld_m, tk_m;

  assign ld_m = sel_mask(4'(load_sel));
  assign tk_m = sel_mask(4'(take_sel));

  for (genvar g = 0; g < int'(NB); g++) begin : g_byte
    logic ld_hit, tk_hit;
    assign ld_hit = load_en & ld_m[g];
    assign tk_hit = take_en & tk_m[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem[g]   <= '0;
        empty[g] <= 1'b1;
      end else begin
        if (ld_hit) mem[g] <= load_data;
        // A local load in the same cycle wins over the bus read.
        empty[g] <= flag_next(empty[g], tk_hit & ~ld_hit, ld_hit);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) underflow_evt <= 1'b0;
    else        underflow_evt <= take_en & empty[take_sel];
  end

  assign take_data = mem[take_sel];
endmodule

// File: rtl/aps_in_bank.sv
module aps_in_bank #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 2,
  localparam int unsigned NB = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          put_en,
  input  logic [AW-1:0] put_sel,
  input  logic [DW-1:0] put_data,
  input  logic          get_en,
  input  logic [AW-1:0] get_sel,
  output logic [DW-1:0] get_data,
  output logic [NB-1:0] full,
  output logic          overflow_evt
);
  import aps_pkg::*;

  logic [DW-1:0]     mem [NB];
  logic [MASK_W-1:0] pt_m, gt_m;

  assign pt_m = sel_mask(4'(put_sel));
  assign gt_m = sel_mask(4'(get_sel));

  for (genvar g = 0; g < int'(NB); g++) begin : g_byte
    logic pt_hit, gt_hit;
    assign pt_hit = put_en & pt_m[g];
    assign gt_hit = get_en & gt_m[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem[g]  <= '0;
        full[g] <= 1'b0;
      end else begin
        // A write into a full byte is dropped.
        if (pt_hit && !full[g]) mem[g] <= put_data;
        full[g] <= flag_next(full[g], pt_hit, gt_hit);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) overflow_evt <= 1'b0;
    else        overflow_evt <= put_en & full[put_sel];
  end

  assign get_data = mem[get_sel];
endmodule

// File: rtl/addr_slave_port.sv
module addr_slave_port #(
  parameter int unsigned DW          = 8,
  parameter int unsigned AW          = 2,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned NB = 1 << AW,
  localparam int unsigned BW = 3 + AW + DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_cs,
  input  logic          ext_rd,
  input  logic          ext_wr,
  input  logic [AW-1:0] ext_addr,
  input  logic [DW-1:0] ext_data_in,
  output logic [DW-1:0] ext_data_out,
  output logic          ext_data_oe,
  input  logic          loc_wr_en,
  input  logic [AW-1:0] loc_wr_sel,
  input  logic [DW-1:0] loc_wr_data,
  input  logic          loc_rd_en,
  input  logic [AW-1:0] loc_rd_sel,
  output logic [DW-1:0] loc_rd_data,
  output logic [NB-1:0] out_empty,
  output logic          all_empty,
  output logic [NB-1:0] in_full,
  output logic          irq_flag,
  input  logic          irq_clr,
  output logic          underflow_evt,
  output logic          overflow_evt
);
  import aps_pkg::*;

  logic [BW-1:0] bus_raw, bus_s;
  logic          s_cs, s_rd, s_wr;
  logic [AW-1:0] bus_addr_s;
  logic [DW-1:0] s_data;
  logic          rd_act, bus_rd_go, bus_wr_go;

  assign bus_raw = {ext_cs, ext_rd, ext_wr, ext_addr, ext_data_in};

  aps_sync #(.W(BW), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(bus_raw), .q(bus_s)
  );

  assign {s_cs, s_rd, s_wr, bus_addr_s, s_data} = bus_s;

  aps_strobe_edge edge_i (
    .clk(clk), .rst_n(rst_n), .cs(s_cs), .rd(s_rd), .wr(s_wr),
    .rd_act(rd_act), .rd_go(bus_rd_go), .wr_go(bus_wr_go)
  );

  aps_out_bank #(.DW(DW), .AW(AW)) obank_i (
    .clk(clk), .rst_n(rst_n),
    .load_en(loc_wr_en), .load_sel(loc_wr_sel), .load_data(loc_wr_data),
    .take_en(bus_rd_go), .take_sel(bus_addr_s), .take_data(ext_data_out),
    .empty(out_empty), .underflow_evt(underflow_evt)
  );

  aps_in_bank #(.DW(DW), .AW(AW)) ibank_i (
    .clk(clk), .rst_n(rst_n),
    .put_en(bus_wr_go), .put_sel(bus_addr_s), .put_data(s_data),
    .get_en(loc_rd_en), .get_sel(loc_rd_sel), .get_data(loc_rd_data),
    .full(in_full), .overflow_evt(overflow_evt)
  );

  assign ext_data_oe = rd_act;
  assign all_empty   = &out_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_flag <= 1'b0;
    else        irq_flag <= flag_next(irq_flag, bus_rd_go | bus_wr_go, irq_clr);
  end
endmodule

// File: rtl/aps_chk.sv
module aps_chk #(
  parameter int unsigned AW = 2,
  localparam int unsigned NB = 1 << AW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_go,
  input logic          wr_go,
  input logic [AW-1:0] s_addr,
  input logic          loc_wr_en,
  input logic [AW-1:0] loc_wr_sel,
  input logic [NB-1:0] out_empty,
  input logic          all_empty,
  input logic [NB-1:0] in_full,
  input logic          underflow_evt,
  input logic          overflow_evt,
  input logic          irq_flag
);
  // R3
  read_sets_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && !(loc_wr_en && loc_wr_sel == s_addr)) |=> out_empty[$past(s_addr)]);

  // R4
  load_clears_agg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loc_wr_en |=> !all_empty);

  // R6
  underflow_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_evt |-> $past(rd_go));

  // R8
  overflow_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && in_full[s_addr]) |=> overflow_evt);

  // R7
  write_sets_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |=> in_full[$past(s_addr)]);

  // R10
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go || wr_go) |=> irq_flag);

  // R11
  single_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_go |=> !rd_go);
endmodule

bind addr_slave_port aps_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .rd_go(bus_rd_go), .wr_go(bus_wr_go),
  .s_addr(bus_addr_s), .loc_wr_en(loc_wr_en), .loc_wr_sel(loc_wr_sel),
  .out_empty(out_empty), .all_empty(all_empty), .in_full(in_full),
  .underflow_evt(underflow_evt), .overflow_evt(overflow_evt), .irq_flag(irq_flag)
);

// File: tb/addr_slave_port_tb.sv
`timescale 1ns/1ps
module addr_slave_port_tb_top;
  localparam int DW = 8;
  localparam int AW = 2;
  localparam int NB = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_cs = 0, ext_rd = 0, ext_wr = 0;
  logic [AW-1:0] ext_addr = '0;
  logic [DW-1:0] ext_data_in = '0;
  logic [DW-1:0] ext_data_out;
  logic ext_data_oe;
  logic loc_wr_en = 0;
  logic [AW-1:0] loc_wr_sel = '0;
  logic [DW-1:0] loc_wr_data = '0;
  logic loc_rd_en = 0;
  logic [AW-1:0] loc_rd_sel = '0;
  logic [DW-1:0] loc_rd_data;
  logic [NB-1:0] out_empty, in_full;
  logic all_empty, irq_flag, underflow_evt, overflow_evt;
  logic irq_clr = 0;

  always #4 clk = ~clk;

  addr_slave_port #(.DW(DW), .AW(AW)) dut_i (.*);

  int checks = 0, failures = 0;
  int uf_seen = 0, of_seen = 0;
  logic [DW-1:0] m_out [NB];
  logic [DW-1:0] m_in  [NB];
  logic [NB-1:0] m_empty = '1, m_full = '0;
  logic m_irq = 0;

  always @(negedge clk) begin
    if (underflow_evt) uf_seen++;
    if (overflow_evt)  of_seen++;
  end

  function automatic logic agg_empty(input logic [NB-1:0] e);
    return e == {NB{1'b1}};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_flags();
    chk("R3/R4 out_empty", 32'(out_empty), 32'(m_empty));
    chk("R5 all_empty", 32'(all_empty), 32'(agg_empty(m_empty)));
    chk("R7/R9 in_full", 32'(in_full), 32'(m_full));
    chk("R10 irq_flag", 32'(irq_flag), 32'(m_irq));
  endtask

  task automatic loc_load(input int i, input logic [DW-1:0] v);
    @(negedge clk);
    loc_wr_en = 1; loc_wr_sel = AW'(i); loc_wr_data = v;
    @(negedge clk);
    loc_wr_en = 0;
    m_out[i] = v; m_empty[i] = 1'b0;
  endtask

  task automatic bus_read(input int i, input int hold);
    int uf0;
    logic exp_uf;
    uf0 = uf_seen;
    exp_uf = m_empty[i];
    @(negedge clk);
    ext_cs = 1; ext_rd = 1; ext_addr = AW'(i);
    repeat (hold) @(negedge clk);
    chk("R1 oe", 32'(ext_data_oe), 1);
    chk("R1 data", 32'(ext_data_out), 32'(m_out[i]));
    ext_cs = 0; ext_rd = 0;
    repeat (4) @(negedge clk);
    chk("R2 oe low", 32'(ext_data_oe), 0);
    m_empty[i] = 1'b1; m_irq = 1'b1;
    chk("R6/R11 underflow count", 32'(uf_seen - uf0), 32'(exp_uf));
    chk_flags();
  endtask

  task automatic bus_write(input int i, input logic [DW-1:0] v);
    int of0;
    logic exp_of;
    of0 = of_seen;
    exp_of = m_full[i];
    @(negedge clk);
    ext_cs = 1; ext_wr = 1; ext_addr = AW'(i); ext_data_in = v;
    repeat (4) @(negedge clk);
    chk("R2 oe during write", 32'(ext_data_oe), 0);
    ext_cs = 0; ext_wr = 0;
    repeat (4) @(negedge clk);
    if (!m_full[i]) m_in[i] = v;
    m_full[i] = 1'b1; m_irq = 1'b1;
    chk("R8 overflow count", 32'(of_seen - of0), 32'(exp_of));
    chk_flags();
  endtask

  task automatic loc_read(input int i);
    @(negedge clk);
    loc_rd_sel = AW'(i);
    #1;
    chk("R9 loc_rd_data", 32'(loc_rd_data), 32'(m_in[i]));
    @(negedge clk);
    loc_rd_en = 1;
    @(negedge clk);
    loc_rd_en = 0;
    m_full[i] = 1'b0;
    chk_flags();
  endtask

  task automatic clear_irq();
    @(negedge clk);
    irq_clr = 1;
    @(negedge clk);
    irq_clr = 0;
    m_irq = 0;
    chk("R10 irq cleared", 32'(irq_flag), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NB; i++) begin m_out[i] = '0; m_in[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    chk("R12 out_empty", 32'(out_empty), 32'hF);
    chk("R12 all_empty", 32'(all_empty), 1);
    chk("R12 in_full", 32'(in_full), 0);
    chk("R12 irq", 32'(irq_flag), 0);
    chk("R12 oe", 32'(ext_data_oe), 0);
    chk("R12 events", 32'({underflow_evt, overflow_evt}), 0);

    // Directed: load each byte with a distinct value, read each twice (R1, R3, R6).
    for (int i = 0; i < NB; i++) loc_load(i, DW'(8'hA0 + i));
    chk("R5 agg clear after loads", 32'(all_empty), 0);
    for (int i = 0; i < NB; i++) bus_read(i, 3);
    chk("R5 agg set when all empty", 32'(all_empty), 1);
    for (int i = 0; i < NB; i++) bus_read(i, 3);
    // R11: long held strobe on an empty byte yields one underflow.
    bus_read(2, 12);
    clear_irq();

    // Directed: write all, overflow one, read back (R7, R8, R9).
    for (int i = 0; i < NB; i++) bus_write(i, DW'(8'h50 + 3 * i));
    bus_write(1, 8'hEE);
    loc_read(1);
    for (int i = 0; i < NB; i++) loc_read(i);
    clear_irq();

    // Constrained random mix.
    for (int n = 0; n < 60; n++) begin
      int op, idx;
      op  = int'($urandom_range(0, 4));
      idx = int'($urandom_range(0, NB - 1));
      case (op)
        0: loc_load(idx, DW'($urandom));
        1: bus_read(idx, 3);
        2: bus_write(idx, DW'($urandom));
        3: loc_read(idx);
        default: clear_irq();
      endcase
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule